// File: doc/BRIEF.md
# Escaped Byte Stream Encoder

This block sits in front of an asynchronous serial transmitter and rewrites an 8-bit data stream so that four byte values never reach the line unprotected. Those values are the escape character 0x19, its top-bit alias 0x99 (the form a 7-bit host with parity may produce), and the two software flow-control characters 0x11 and 0x13. Each special byte is replaced by the escape 0x19 followed by a code byte. When two specials arrive one after the other, a single escape and one combined code replace both. A run of specials therefore grows by at most half instead of doubling.

To decide between a lone code and a combined code, the encoder holds one special byte back until it sees the next byte. A `flush` input forces a held special out on its own, for example at the end of a frame. Both sides use a valid/ready handshake. The encoder takes no new input while it is emitting a multi-byte sequence. Under output backpressure no byte is lost or reordered.

Top module: `byte_escape_encoder`

## Requirements
- R1: A byte that is not 0x19, 0x99, 0x11 or 0x13 and arrives with no special held is emitted unchanged. Bytes keep their order. With `out_ready` held high, the encoder accepts and emits one plain byte per cycle.
- R2: A held special followed by a plain byte is emitted as 0x19, then a single code, then the plain byte. The single codes are 0x5C for 0x19, 0x76 for 0x99, 0xA0 for 0x11 and 0xA1 for 0x13.
- R3: Two consecutive specials A then B are emitted as 0x19 followed by 0x80 + 4*idx(A) + idx(B). The index is 0 for 0x19, 1 for 0x99, 2 for 0x11 and 3 for 0x13. Pairs are formed greedily from the start of a run, so the third special of a run starts a new pair.
- R4: An incoming special with nothing held produces no output until the next byte or a flush. While `flush` is high and a special is held, `in_ready` is low and the held special goes out as 0x19 plus its single code. A flush with nothing held has no effect.
- R5: The output never carries 0x99, 0x11 or 0x13. Every 0x19 on the output is an escape, and the byte after it is one of the single codes or a value in the range 0x80 to 0x8F.
- R6: `in_ready` is high only when the output register will be empty after the current cycle's transfer. As a result, input is refused while the second or third byte of a sequence is waiting.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R8: After reset `out_valid` is low, `in_ready` is high and no special is held. A special held before a reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Encoder accepts the input byte this cycle |
| in_data | input | 8 | Input data byte |
| flush | input | 1 | Emit a held special as a single sequence |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Transmitter takes the output byte |
| out_data | output | 8 | Encoded output byte |

## Verification
The hardest case to reach is a held special meeting a new byte while the transmitter stalls. In that case the three-byte sequence must wait in the output register, input must stay refused, and the pair or single decision must still be made correctly. The stimulus reaches it in three ways. A random stream is half specials while `out_ready` toggles at random. Long runs of 0x19 exercise the greedy pairing and the odd trailing flush. A directed test loads a combined sequence with `out_ready` held low and then checks that input is refused and the output is stable.

// File: rtl/esc_enc_pkg.sv
package esc_enc_pkg;

  localparam logic [7:0] ESC_BYTE  = 8'h19;
  localparam logic [7:0] PAIR_BASE = 8'h80;

  typedef logic [1:0] spec_idx_t;

  // Code sent after the escape for one isolated special byte.
  function automatic logic [7:0] single_code(spec_idx_t idx);
    case (idx)
      2'd0:    single_code = 8'h5C;
      2'd1:    single_code = 8'h76;
      2'd2:    single_code = 8'hA0;
      default: single_code = 8'hA1;
    endcase
  endfunction

  // Code sent after the escape for an ordered pair of specials.
  function automatic logic [7:0] pair_code(spec_idx_t first, spec_idx_t second);
    pair_code = PAIR_BASE | {4'h0, first, second};
  endfunction

  function automatic logic is_code(logic [7:0] b);
    is_code = (b == 8'h5C) || (b == 8'h76) || (b == 8'hA0) || (b == 8'hA1) ||
              (b[7:4] == PAIR_BASE[7:4]);
  endfunction

endpackage

// File: rtl/esc_special_detect.sv
module esc_special_detect
  import esc_enc_pkg::*;
(
  input  logic [7:0] data,
  output logic       is_special,
  output spec_idx_t  idx
);

  always_comb begin
    is_special = 1'b1;
    idx        = 2'd0;
    case (data)
      8'h19:   idx = 2'd0;
      8'h99:   idx = 2'd1;
      8'h11:   idx = 2'd2;
      8'h13:   idx = 2'd3;
      default: is_special = 1'b0;
    endcase
  end

endmodule

// File: rtl/esc_seq_builder.sv
module esc_seq_builder
  import esc_enc_pkg::*;
#(
  parameter int SEQ_MAX = 3,
  parameter int CNT_W   = $clog2(SEQ_MAX + 1)
) (
  input  logic                    pend_v,
  input  spec_idx_t               pend_idx,
  input  logic                    take,
  input  logic                    do_flush,
  input  logic [7:0]              in_data,
  input  logic                    in_special,
  input  spec_idx_t               in_idx,
  output logic [CNT_W-1:0]        push_n,
  output logic [SEQ_MAX-1:0][7:0] seq,
  output logic                    pend_v_nxt,
  output spec_idx_t               pend_idx_nxt
);

  always_comb begin
    push_n       = '0;
    seq          = '0;
    pend_v_nxt   = pend_v;
    pend_idx_nxt = pend_idx;
    if (take) begin
      if (pend_v && in_special) begin
        seq[0]     = ESC_BYTE;
        seq[1]     = pair_code(pend_idx, in_idx);
        push_n     = CNT_W'(2);
        pend_v_nxt = 1'b0;
      end else if (pend_v) begin
        seq[0]     = ESC_BYTE;
        seq[1]     = single_code(pend_idx);
        seq[2]     = in_data;
        push_n     = CNT_W'(3);
        pend_v_nxt = 1'b0;
      end else if (in_special) begin
        pend_v_nxt   = 1'b1;
        pend_idx_nxt = in_idx;
      end else begin
        seq[0] = in_data;
        push_n = CNT_W'(1);
      end
    end else if (do_flush) begin
      seq[0]     = ESC_BYTE;
      seq[1]     = single_code(pend_idx);
      push_n     = CNT_W'(2);
      pend_v_nxt = 1'b0;
    end
  end

endmodule

// File: rtl/esc_out_queue.sv
module esc_out_queue #(
  parameter int DEPTH = 3,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      push_n,
  input  logic [DEPTH-1:0][7:0] push_bytes,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [7:0]            out_data,
  output logic                  free
);

  logic [7:0]       q     [DEPTH];
  logic [7:0]       q_nxt [DEPTH];
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             pop, push, ld;

  assign out_valid = (cnt != '0);
  assign out_data  = q[0];
  assign pop       = out_valid && out_ready;
  assign push      = (push_n != '0);
  assign ld        = push || pop;
  assign free      = (cnt == '0) || ((cnt == CNT_W'(1)) && out_ready);

  always_comb begin
    if (push)     cnt_nxt = push_n;
    else if (pop) cnt_nxt = cnt - CNT_W'(1);
    else          cnt_nxt = cnt;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i < DEPTH - 1) begin : g_shift
      always_comb begin
        if (push)     q_nxt[i] = push_bytes[i];
        else if (pop) q_nxt[i] = q[i+1];
        else          q_nxt[i] = q[i];
      end
    end else begin : g_last
      always_comb begin
        if (push) q_nxt[i] = push_bytes[i];
        else      q_nxt[i] = q[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= '0;
      else if (ld) q[i] <= q_nxt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (ld) cnt <= cnt_nxt;
  end

  assert_push_only_when_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> free);
  assert_refuse_when_backed_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CNT_W'(1)) |-> !free);
  assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/byte_escape_encoder.sv
module byte_escape_encoder
  import esc_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       flush,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);

  localparam int SEQ_MAX = 3;
  localparam int CNT_W   = $clog2(SEQ_MAX + 1);

  logic                    pend_v, pend_v_nxt;
  spec_idx_t               pend_idx, pend_idx_nxt;
  logic                    in_special;
  spec_idx_t               in_idx;
  logic                    free, take, do_flush, pend_en;
  logic [CNT_W-1:0]        push_n;
  logic [SEQ_MAX-1:0][7:0] seq;

  assign in_ready = free && !(flush && pend_v);
  assign take     = in_valid && in_ready;
  assign do_flush = flush && pend_v && free;
  assign pend_en  = take || do_flush;

  esc_special_detect i_detect (
    .data       (in_data),
    .is_special (in_special),
    .idx        (in_idx)
  );

  esc_seq_builder #(.SEQ_MAX(SEQ_MAX), .CNT_W(CNT_W)) i_build (
    .pend_v       (pend_v),
    .pend_idx     (pend_idx),
    .take         (take),
    .do_flush     (do_flush),
    .in_data      (in_data),
    .in_special   (in_special),
    .in_idx       (in_idx),
    .push_n       (push_n),
    .seq          (seq),
    .pend_v_nxt   (pend_v_nxt),
    .pend_idx_nxt (pend_idx_nxt)
  );

  esc_out_queue #(.DEPTH(SEQ_MAX), .CNT_W(CNT_W)) i_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_n     (push_n),
    .push_bytes (seq),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .free       (free)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_idx <= '0;
    end else if (pend_en) begin
      pend_v   <= pend_v_nxt;
      pend_idx <= pend_idx_nxt;
    end
  end

  // Tracks whether the byte now at the output follows an emitted escape.
  logic after_esc, after_esc_nxt;
  always_comb begin
    after_esc_nxt = after_esc;
    if (out_valid && out_ready) after_esc_nxt = (out_data == ESC_BYTE) && !after_esc;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) after_esc <= 1'b0;
    else        after_esc <= after_esc_nxt;
  end

  assert_no_raw_special_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !((out_data == 8'h99) || (out_data == 8'h11) || (out_data == 8'h13)));
  assert_code_after_escape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && after_esc) |-> is_code(out_data));
  assert_plain_passes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !pend_v && !in_special) |=> (out_valid && out_data == $past(in_data)));
  assert_pair_starts_escape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pend_v) |=> (out_valid && out_data == ESC_BYTE));
  assert_flush_blocks_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && pend_v) |-> !in_ready);
  assert_held_special_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !pend_v && in_special) |=> pend_v);

endmodule

// File: tb/test_byte_escape_encoder.sv
module test_byte_escape_encoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       flush = 1'b0;
  logic       out_ready = 1'b0;
  logic       in_ready, out_valid;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  byte_escape_encoder i_byte_escape_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .flush(flush), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int ready_mode = 0;  // 0: always ready, 1: random, 2: stalled
  logic [7:0] in_q [$];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];

  // Case table: input bytes, expected output bytes, requirement tag.
  localparam int NC = 9;
  localparam logic [7:0] TIN [NC][4] = '{
    '{8'h41, 8'h00, 8'hFF, 8'h7E},  // R1 plain bytes
    '{8'h19, 8'h41, 8'h00, 8'h00},  // R2
    '{8'h13, 8'h20, 8'h00, 8'h00},  // R2
    '{8'h99, 8'h11, 8'h00, 8'h00},  // R3
    '{8'h19, 8'h19, 8'h19, 8'h00},  // R3 odd run, trailing flush
    '{8'h11, 8'h13, 8'h99, 8'h19},  // R3 two pairs
    '{8'h99, 8'h00, 8'h00, 8'h00},  // R4 flushed single
    '{8'h13, 8'h11, 8'h00, 8'h00},  // R3
    '{8'h11, 8'h55, 8'h99, 8'h19}   // R2 then R3
  };
  localparam int TIN_N [NC] = '{4, 2, 2, 2, 3, 4, 1, 2, 4};
  localparam logic [7:0] TOUT [NC][6] = '{
    '{8'h41, 8'h00, 8'hFF, 8'h7E, 8'h00, 8'h00},
    '{8'h19, 8'h5C, 8'h41, 8'h00, 8'h00, 8'h00},
    '{8'h19, 8'hA1, 8'h20, 8'h00, 8'h00, 8'h00},
    '{8'h19, 8'h86, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h19, 8'h80, 8'h19, 8'h5C, 8'h00, 8'h00},
    '{8'h19, 8'h8B, 8'h19, 8'h84, 8'h00, 8'h00},
    '{8'h19, 8'h76, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h19, 8'h8E, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h19, 8'hA0, 8'h55, 8'h19, 8'h84, 8'h00}
  };
  localparam int TOUT_N [NC] = '{4, 3, 3, 2, 4, 4, 2, 2, 5};
  localparam string TREQ [NC] = '{"R1", "R2", "R2", "R3", "R3", "R3", "R4", "R3", "R2"};

  task automatic check_val(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Output monitor: picks up every byte transferred.
  initial begin
    forever begin
      @(negedge clk);
      case (ready_mode)
        0:       out_ready = 1'b1;
        1:       out_ready = ($urandom % 2) == 0;
        default: out_ready = 1'b0;
      endcase
      #1;
      if (rst_n && out_valid && out_ready) got_q.push_back(out_data);
    end
  end

  task automatic push_byte(input logic [7:0] b);
    bit acc = 1'b0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!acc) begin
      #2;
      acc = in_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic do_flush();
    bit idle = 1'b0;
    @(negedge clk);
    flush = 1'b1;
    while (!idle) begin
      #2;
      idle = !out_valid;
      @(posedge clk);
      if (!idle) @(negedge clk);
    end
    #1 flush = 1'b0;
  endtask

  task automatic drain();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      #3;
      if (out_valid) quiet = 0; else quiet++;
    end
  endtask

  function automatic int spec_idx(logic [7:0] b);
    case (b)
      8'h19: return 0;
      8'h99: return 1;
      8'h11: return 2;
      8'h13: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] single_of(int i);
    logic [7:0] t [4] = '{8'h5C, 8'h76, 8'hA0, 8'hA1};
    return t[i];
  endfunction

  // Reference encoding of in_q with a flush at the end.
  task automatic build_expected();
    int pend = -1;
    exp_q.delete();
    foreach (in_q[i]) begin
      int s = spec_idx(in_q[i]);
      if (pend >= 0) begin
        exp_q.push_back(8'h19);
        if (s >= 0) exp_q.push_back(8'(8'h80 + 4 * pend + s));
        else begin
          exp_q.push_back(single_of(pend));
          exp_q.push_back(in_q[i]);
        end
        pend = -1;
      end else if (s >= 0) pend = s;
      else exp_q.push_back(in_q[i]);
    end
    if (pend >= 0) begin
      exp_q.push_back(8'h19);
      exp_q.push_back(single_of(pend));
    end
  endtask

  task automatic run_stream();
    got_q.delete();
    foreach (in_q[i]) push_byte(in_q[i]);
    do_flush();
    drain();
  endtask

  task automatic compare_stream(string req);
    check_val({req, " length"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check_val(req, got_q[i], exp_q[i]);
  endtask

  // R5: scan for unescaped specials and malformed escapes.
  task automatic scan_clean();
    int bad = 0;
    for (int i = 0; i < got_q.size(); i++) begin
      logic [7:0] b = got_q[i];
      if (b == 8'h99 || b == 8'h11 || b == 8'h13) bad++;
      if (b == 8'h19) begin
        if (i + 1 >= got_q.size()) bad++;
        else begin
          logic [7:0] c = got_q[i+1];
          if (!(c == 8'h5C || c == 8'h76 || c == 8'hA0 || c == 8'hA1 || c[7:4] == 4'h8)) bad++;
          i++;
        end
      end
    end
    check_val("R5 raw special scan", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check_val("R8 out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    check_val("R8 out_valid after reset", out_valid, 0);
    check_val("R8 in_ready after reset", in_ready, 1);

    // Table walk
    for (int c = 0; c < NC; c++) begin
      in_q.delete();
      exp_q.delete();
      for (int k = 0; k < TIN_N[c]; k++) in_q.push_back(TIN[c][k]);
      for (int k = 0; k < TOUT_N[c]; k++) exp_q.push_back(TOUT[c][k]);
      ready_mode = c % 2;
      run_stream();
      compare_stream(TREQ[c]);
    end

    // R1: full rate with out_ready high
    ready_mode = 0;
    got_q.delete();
    @(negedge clk);
    in_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      in_data = 8'(8'h30 + k);
      #2;
      check_val("R1 in_ready at full rate", in_ready, 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    drain();
    check_val("R1 full rate count", got_q.size(), 5);

    // R4: held special stays silent; flush with nothing held is harmless
    got_q.delete();
    push_byte(8'h13);
    repeat (4) @(negedge clk);
    #3;
    check_val("R4 held special silent", out_valid, 0);
    in_q.delete(); in_q.push_back(8'h13); build_expected();
    do_flush();
    drain();
    compare_stream("R4 flush single");
    got_q.delete();
    @(negedge clk);
    flush = 1'b1;
    repeat (3) begin
      @(negedge clk);
      #3;
      check_val("R4 idle flush no output", out_valid, 0);
    end
    flush = 1'b0;

    // R6, R7: stalled output with a queued pair
    got_q.delete();
    ready_mode = 2;
    push_byte(8'h19);
    push_byte(8'h19);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h41;
    for (int k = 0; k < 3; k++) begin
      #3;
      check_val("R6 input refused while backed up", in_ready, 0);
      check_val("R7 out_valid held", out_valid, 1);
      check_val("R7 out_data held", out_data, 8'h19);
      @(negedge clk);
    end
    ready_mode = 0;
    in_valid = 1'b0;
    push_byte(8'h41);
    drain();
    in_q.delete(); in_q = '{8'h19, 8'h19, 8'h41}; build_expected();
    compare_stream("R6 stalled pair order");

    // R8: reset discards a held special
    got_q.delete();
    push_byte(8'h11);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    push_byte(8'h41);
    do_flush();
    drain();
    in_q.delete(); in_q.push_back(8'h41); build_expected();
    compare_stream("R8 held special discarded");

    // R3: long runs of the escape value
    ready_mode = 1;
    for (int len = 20; len <= 21; len++) begin
      in_q.delete();
      for (int k = 0; k < len; k++) in_q.push_back(8'h19);
      build_expected();
      run_stream();
      compare_stream("R3 escape run");
      check_val("R3 run expansion", got_q.size(), (len / 2) * 2 + (len % 2) * 2);
      scan_clean();
    end

    // R2, R3, R5: random streams, half specials, random backpressure
    for (int r = 0; r < 4; r++) begin
      in_q.delete();
      for (int k = 0; k < 300; k++) begin
        if ($urandom % 2 == 0) begin
          case ($urandom % 4)
            0: in_q.push_back(8'h19);
            1: in_q.push_back(8'h99);
            2: in_q.push_back(8'h11);
            default: in_q.push_back(8'h13);
          endcase
        end else in_q.push_back(8'($urandom));
      end
      build_expected();
      run_stream();
      compare_stream("R2/R3 random stream");
      scan_clean();
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule